// File: doc/BRIEF.md
# Floppy Control Latch with Clock Divider and Halt-Time NMI Gate

This block sits beside a floppy disk controller and holds its mode settings. The CPU writes one byte to a single I/O port. The block keeps four fields from that byte: which of two drives is selected, which disk side is used, whether double-density (MFM) recording is on, and whether high-density operation is on. The high-density bit also drives a select line that switches the write-precompensation network to its second set of trims.

The block also makes the controller's clock. A prescaler divides the system clock down to a tick stream. A first flip-flop toggles on each tick and gives the fast (high-density) clock. A second, separate flip-flop halves that and gives the standard clock. The high-density bit picks which of the two reaches the controller, so setting it doubles the controller clock.

A slow CPU cannot service a high-density data stream by polling. To help it, a small state machine drives an active-low NMI when three things hold at once: high density is on, the CPU reports that it is halted, and the controller raises its interrupt or its data request. The state machine has three states. NMI_IDLE means high density is off. NMI_WAIT means high density is on but the trigger is incomplete. NMI_DRIVE means the NMI is pulled low. From any state, the next state is NMI_IDLE when high density is off. Otherwise it is NMI_DRIVE when the full trigger holds, and NMI_WAIT when it does not.

Top module: `fdc_ctl_latch`

## Requirements
- R1: After reset, drv_b_sel, side_sel, dden_en, hd_en, precomp_sel and fdc_clk are 0, and nmi_n is 1.
- R2: A write with io_wr=1 and io_addr=48h is captured on the clock edge and shows at the outputs in the next cycle. The fields are data bit 0 to drv_b_sel (1 = drive B), bit 2 to side_sel, bit 3 to dden_en and bit 4 to hd_en. Bits 1, 5, 6 and 7 are ignored.
- R3: A cycle with io_wr=0, or with io_addr other than 48h, leaves every latched output unchanged.
- R4: precomp_sel always equals hd_en.
- R5: With hd_en=0, fdc_clk is a square wave with a period of 4*PRESCALE system clocks (8 at the default). It is the output of the second flip-flop, which toggles only when the first flip-flop falls.
- R6: With hd_en=1, fdc_clk has a period of 2*PRESCALE system clocks (4 at the default), which is twice the standard rate.
- R7: When hd_en=1, cpu_halt_n=0, and fdc_intrq=1 or fdc_drq=1, nmi_n goes low one cycle later. Either request source alone is enough.
- R8: nmi_n returns high one cycle after any of those conditions drops.
- R9: With hd_en=0, nmi_n stays high whatever cpu_halt_n, fdc_intrq and fdc_drq do.
- R10: Writing 08h gives dden_en=1 and hd_en=0 with the standard clock. Writing 18h gives dden_en=1 and hd_en=1 with the doubled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source of the controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| cpu_halt_n | input | 1 | CPU halted indication, active low |
| fdc_intrq | input | 1 | Controller interrupt request, active high |
| fdc_drq | input | 1 | Controller data request, active high |
| drv_b_sel | output | 1 | 0 selects drive A, 1 selects drive B |
| side_sel | output | 1 | Disk side select |
| dden_en | output | 1 | Double-density (MFM) enable |
| hd_en | output | 1 | High-density enable |
| precomp_sel | output | 1 | Selects the second precompensation set |
| fdc_clk | output | 1 | Clock to the floppy controller |
| nmi_n | output | 1 | Non-maskable interrupt to the CPU, active low |

## Verification
On every cycle, the assertions check the following. The latch holds when no write reaches its port. The standard-clock flip-flop changes only as the fast flip-flop falls. NMI follows the three-way trigger into NMI_DRIVE and leaves it one cycle after the trigger breaks. Only the bench's scenarios show the rest. These are the exact field positions after writes such as 08h and 18h, the reset values, and the measured clock periods in both density modes. They also include the behaviour with high density off while the CPU is halted and requests are present.

// File: rtl/fdl_pkg.sv
package fdl_pkg;

    // Bit positions inside the written byte
    localparam int BIT_DRV  = 0;
    localparam int BIT_SIDE = 2;
    localparam int BIT_DDEN = 3;
    localparam int BIT_HD   = 4;

    typedef struct packed {
        logic hd;
        logic dden;
        logic side;
        logic drv_b;
    } fdl_ctrl_t;

    typedef enum logic [1:0] {
        NMI_IDLE  = 2'd0,
        NMI_WAIT  = 2'd1,
        NMI_DRIVE = 2'd2
    } nmi_state_e;

endpackage

// File: rtl/fdl_ctrl_reg.sv
module fdl_ctrl_reg
    import fdl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PORT = 8'h48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output fdl_ctrl_t         ctrl_q
);

    logic      hit;
    fdl_ctrl_t ctrl_d;

    assign hit = wr_en && (addr == PORT);

    always_comb begin
        ctrl_d.drv_b = wdata[BIT_DRV];
        ctrl_d.side  = wdata[BIT_SIDE];
        ctrl_d.dden  = wdata[BIT_DDEN];
        ctrl_d.hd    = wdata[BIT_HD];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (hit) begin
            ctrl_q <= ctrl_d;
        end
    end

    // R3: no write to the port, no change in the latch
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(ctrl_q));

endmodule

// File: rtl/fdl_clk_div.sv
module fdl_clk_div #(
    parameter int PRESCALE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hd,
    output logic fdc_clk
);

    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic tick;
    logic fast_q;
    logic slow_q;

    generate
        if (PRESCALE > 1) begin : g_pre
            logic [CW-1:0] cnt_q;
            assign tick = (cnt_q == CW'(PRESCALE - 1));
            always_ff @(posedge clk) begin
                if (!rst_n || tick) cnt_q <= '0;
                else                cnt_q <= cnt_q + 1'b1;
            end
        end else begin : g_nopre
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
            slow_q <= 1'b0;
        end else if (tick) begin
            fast_q <= ~fast_q;
            if (fast_q) slow_q <= ~slow_q;
        end
    end

    assign fdc_clk = hd ? fast_q : slow_q;

    // R5: the halving flip-flop moves only as the fast flip-flop falls
    assert_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slow_q) |-> $fell(fast_q));

endmodule

// File: rtl/fdl_nmi_fsm.sv
module fdl_nmi_fsm
    import fdl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hd,
    input  logic halt_n,
    input  logic intrq,
    input  logic drq,
    output logic nmi_n
);

    nmi_state_e state_q, state_d;
    logic       trig;

    assign trig = hd && !halt_n && (intrq || drq);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NMI_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_IDLE:  state_d = !hd ? NMI_IDLE : (trig ? NMI_DRIVE : NMI_WAIT);
            NMI_WAIT:  state_d = !hd ? NMI_IDLE : (trig ? NMI_DRIVE : NMI_WAIT);
            NMI_DRIVE: state_d = !hd ? NMI_IDLE : (trig ? NMI_DRIVE : NMI_WAIT);
            default:   state_d = NMI_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            NMI_DRIVE: nmi_n = 1'b0;
            default:   nmi_n = 1'b1;
        endcase
    end

    // R7: a full trigger pulls NMI low on the next cycle
    assert_nmi_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !nmi_n);
    // R8: any broken condition releases NMI on the next cycle
    assert_nmi_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> nmi_n);
    // R9: NMI never low while high density was off the cycle before
    assert_nmi_hdoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hd |=> nmi_n);

endmodule

// File: rtl/fdc_ctl_latch.sv
module fdc_ctl_latch
    import fdl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PORT = 8'h48,
    parameter int PRESCALE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              cpu_halt_n,
    input  logic              fdc_intrq,
    input  logic              fdc_drq,
    output logic              drv_b_sel,
    output logic              side_sel,
    output logic              dden_en,
    output logic              hd_en,
    output logic              precomp_sel,
    output logic              fdc_clk,
    output logic              nmi_n
);

    fdl_ctrl_t ctrl;

    fdl_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT(PORT)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (io_wr),
        .addr   (io_addr),
        .wdata  (io_wdata),
        .ctrl_q (ctrl)
    );

    fdl_clk_div #(.PRESCALE(PRESCALE)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .hd      (ctrl.hd),
        .fdc_clk (fdc_clk)
    );

    fdl_nmi_fsm u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .hd     (ctrl.hd),
        .halt_n (cpu_halt_n),
        .intrq  (fdc_intrq),
        .drq    (fdc_drq),
        .nmi_n  (nmi_n)
    );

    assign drv_b_sel   = ctrl.drv_b;
    assign side_sel    = ctrl.side;
    assign dden_en     = ctrl.dden;
    assign hd_en       = ctrl.hd;
    assign precomp_sel = ctrl.hd;

endmodule

// File: tb/sim_fdc_ctl_latch.sv
module sim_fdc_ctl_latch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       cpu_halt_n = 1'b1;
    logic       fdc_intrq = 1'b0;
    logic       fdc_drq = 1'b0;
    logic       drv_b_sel, side_sel, dden_en, hd_en, precomp_sel, fdc_clk, nmi_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fdc_ctl_latch u0 (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .cpu_halt_n(cpu_halt_n), .fdc_intrq(fdc_intrq),
        .fdc_drq(fdc_drq), .drv_b_sel(drv_b_sel), .side_sel(side_sel),
        .dden_en(dden_en), .hd_en(hd_en), .precomp_sel(precomp_sel),
        .fdc_clk(fdc_clk), .nmi_n(nmi_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // outputs packed as {hd,dden,side,drv_b}
    function automatic int fields();
        return {hd_en, dden_en, side_sel, drv_b_sel};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic strobe);
        @(negedge clk);
        io_wr = strobe; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic measure(output int period);
        bit prev;
        int n;
        repeat (12) @(negedge clk);
        prev = fdc_clk;
        forever begin
            @(negedge clk);
            if (!prev && fdc_clk) break;
            prev = fdc_clk;
        end
        n = 0;
        prev = fdc_clk;
        forever begin
            @(negedge clk);
            n++;
            if (!prev && fdc_clk) break;
            prev = fdc_clk;
        end
        period = n;
    endtask

    task automatic t_reset_R1();
        @(negedge clk);
        chk("R1 fields", fields(), 0);
        chk("R1 precomp", precomp_sel, 0);
        chk("R1 nmi_n", nmi_n, 1);
        chk("R1 fdc_clk", fdc_clk, 0);
    endtask

    task automatic t_fields_R2();
        wr(8'h48, 8'h01, 1); chk("R2 drive bit0", fields(), 4'b0001);
        wr(8'h48, 8'h04, 1); chk("R2 side bit2", fields(), 4'b0010);
        wr(8'h48, 8'hE2, 1); chk("R2 ignored bits 1,5-7", fields(), 4'b0000);
        wr(8'h48, 8'h1D, 1); chk("R2 all fields", fields(), 4'b1111);
        chk("R4 precomp follows hd", precomp_sel, 1);
    endtask

    task automatic t_ignore_R3();
        wr(8'h49, 8'h00, 1); chk("R3 other port", fields(), 4'b1111);
        wr(8'h48, 8'h00, 0); chk("R3 no strobe", fields(), 4'b1111);
        wr(8'h08, 8'h00, 1); chk("R3 alias port", fields(), 4'b1111);
    endtask

    task automatic t_clock_R5_R6_R10();
        int p;
        wr(8'h48, 8'h08, 1);
        chk("R10 08h fields", fields(), 4'b0100);
        chk("R4 precomp off", precomp_sel, 0);
        measure(p); chk("R5 standard period", p, 8);
        wr(8'h48, 8'h18, 1);
        chk("R10 18h fields", fields(), 4'b1100);
        measure(p); chk("R6 doubled period", p, 4);
    endtask

    task automatic t_nmi_R7_R8_R9();
        // hd still on from 18h
        @(negedge clk); cpu_halt_n = 1'b0; fdc_intrq = 1'b1;
        @(negedge clk); chk("R7 intrq fires", nmi_n, 0);
        fdc_intrq = 1'b0;
        @(negedge clk); chk("R8 release on request drop", nmi_n, 1);
        fdc_drq = 1'b1;
        @(negedge clk); chk("R7 drq fires", nmi_n, 0);
        cpu_halt_n = 1'b1;
        @(negedge clk); chk("R8 release on halt drop", nmi_n, 1);
        cpu_halt_n = 1'b0;
        @(negedge clk); chk("R7 refire", nmi_n, 0);
        io_wr = 1'b1; io_addr = 8'h48; io_wdata = 8'h08;
        @(negedge clk); io_wr = 1'b0;
        chk("R8 hd cleared, latch", hd_en, 0);
        @(negedge clk); chk("R8 release on hd drop", nmi_n, 1);
        fdc_intrq = 1'b1;
        repeat (3) begin
            @(negedge clk); chk("R9 hd off blocks nmi", nmi_n, 1);
        end
        fdc_intrq = 1'b0; fdc_drq = 1'b0; cpu_halt_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_R1();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_fields_R2();
        t_ignore_R3();
        t_clock_R5_R6_R10();
        t_nmi_R7_R8_R9();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule